// File: doc/BRIEF.md
# RSA Key Slot Store Controller

This block keeps a small set of RSA private keys in on-chip memories and moves them between those memories and an external synchronous staging SRAM. Software never writes the key memories directly. It places key material in the staging SRAM over a 32-bit path. It then issues a command that names a slot, a direction, a key length and a base address. The controller walks the key one 32-bit word per cycle and reports completion with a one-cycle `done_o` pulse.

A key has eight components: p, q, N, E, D, dP, dQ and qInv. Each component lives in its own memory bank, indexed by slot and word. N, E and D are each keybits/32 words long. The other five are keybits/64 words long. In the staging SRAM the components sit back to back in that order from the base address, each one least significant word first. E is zero-padded by the host to full length. A clear command zeroes every word of one slot without touching the SRAM. The default build holds 4 slots and keys of up to 1024 bits.

Top module: `kstore_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after reset, `busy_o`, `done_o`, `err_o` and `sram_req_o` are low.
- R2: A load (`cmd_i`=0) reads SRAM words at base, base+1, ... one per cycle in component order p, q, N, E, D, dP, dQ, qInv. N, E and D span 16<<`klen_i` words each and the rest span 8<<`klen_i` words each, so the command is busy for 88<<`klen_i` cycles before `done_o`.
- R3: A read (`cmd_i`=1) writes the slot to SRAM in the same layout and order, one word per cycle. Data read back after a load equals the loaded data.
- R4: `klen_i` code k selects 512<<k bits. A code whose size exceeds MAX_KEY_BITS (codes 2 and 3 by default) is rejected. A load with a short key fills only its low words and leaves each component's upper words unchanged.
- R5: A command whose `slot_i` is NUM_SLOTS or above is rejected. `done_o` and `err_o` pulse on the next cycle, no SRAM access takes place, and no slot changes.
- R6: `cmd_i`=3 is rejected in the same way as R5.
- R7: Clear (`cmd_i`=2) zeroes all MAX_KEY_BITS words of the selected slot in 3*MAX/32+5*MAX/64 cycles, whatever `klen_i` is, with no SRAM access.
- R8: A load into one slot leaves every other slot unchanged.
- R9: `start_i` is ignored while `busy_o` is high.
- R10: Every command ends with exactly one cycle of `done_o`. `err_o` is high only with `done_o`. `busy_o` stays high up to and including that cycle and is low in the next one.
- R11: The SRAM has a one-cycle read latency. `sram_req_o` is low while idle, and `sram_we_o` is only asserted together with `sram_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, sampled while idle |
| cmd_i | input | 2 | 0 load, 1 read, 2 clear, 3 reserved |
| slot_i | input | SLOT_IN_W (3) | Target key slot |
| klen_i | input | 2 | Key length code, 512<<k bits |
| base_i | input | ADDR_W (16) | SRAM word address of the first key word |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Command rejected, valid with done_o |
| sram_req_o | output | 1 | SRAM access this cycle |
| sram_we_o | output | 1 | SRAM write when high, read when low |
| sram_addr_o | output | ADDR_W (16) | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, one cycle after the read request |

## Verification
The sharpest corner is a 512-bit load into a slot that was cleared and is then read back at 1024 bits. Each component's low half must hold the loaded words and its upper half must be zero. A design with the wrong component order or the wrong per-component lengths places words in the wrong banks, and the mismatches show up position by position. A slot number that is in range only after truncation, such as 5, is sent with fresh data. A design that wraps the slot index instead of rejecting it corrupts slot 1, and a later read of that slot exposes it. A clear strobed in the middle of a load must be dropped: a design that honours it either stops short, which shows in the cycle count, or zeroes the slot, which shows in the readback. Busy-cycle counts per key length and SRAM access counts per command catch off-by-one word limits and stray accesses on rejected commands.

// File: rtl/kstore_pkg.sv
package kstore_pkg;
  localparam int unsigned NUM_COMP = 8;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    CMD_LOAD  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_CLEAR = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY_IN,
    ST_COPY_OUT,
    ST_CLEAR,
    ST_DONE
  } state_e;

  // components 2..4 (N, E, D) are full key length, the rest half
  function automatic logic comp_is_full(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction
endpackage

// File: rtl/kstore_seq.sv
module kstore_seq
  import kstore_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic [1:0]        len_code_i,
  output logic [2:0]        comp_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] offs_o,
  output logic              last_o
);
  localparam int LW = WORD_W + 1;

  logic [2:0]        comp_q;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] offs_q;
  logic [LW-1:0]     base_len, lim_m1;
  logic              word_end;

  always_comb begin
    base_len = comp_is_full(comp_q) ? LW'(16) : LW'(8);
    lim_m1   = (base_len << len_code_i) - LW'(1);
    word_end = ({1'b0, word_q} == lim_m1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q <= '0;
      word_q <= '0;
      offs_q <= '0;
    end else if (init_i) begin
      comp_q <= '0;
      word_q <= '0;
      offs_q <= '0;
    end else if (step_i) begin
      offs_q <= offs_q + ADDR_W'(1);
      if (word_end) begin
        word_q <= '0;
        comp_q <= comp_q + 3'd1;
      end else begin
        word_q <= word_q + WORD_W'(1);
      end
    end
  end

  assign comp_o = comp_q;
  assign word_o = word_q;
  assign offs_o = offs_q;
  assign last_o = (comp_q == 3'd7) && word_end;
endmodule

// File: rtl/kstore_bank.sv
module kstore_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int DEPTH     = 32,
  parameter int SLOT_W    = 2,
  parameter int WORD_W    = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] wword_i,
  input  logic [31:0]       wdata_i,
  input  logic [WORD_W-1:0] rword_i,
  output logic [31:0]       rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0] mem [NUM_SLOTS*DEPTH];
  logic [SLOT_W+AW-1:0] widx, ridx;

  assign widx = {slot_i, wword_i[AW-1:0]};
  assign ridx = {slot_i, rword_i[AW-1:0]};

  always_ff @(posedge clk_i) begin
    if (we_i) mem[widx] <= wdata_i;
    rdata_o <= mem[ridx];
  end
endmodule

// File: rtl/kstore_ctrl.sv
module kstore_ctrl
  import kstore_pkg::*;
#(
  parameter int NUM_SLOTS    = 4,
  parameter int MAX_KEY_BITS = 1024,
  parameter int ADDR_W       = 16,
  parameter int SLOT_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  parameter int SLOT_IN_W    = SLOT_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           cmd_i,
  input  logic [SLOT_IN_W-1:0] slot_i,
  input  logic [1:0]           klen_i,
  input  logic [ADDR_W-1:0]    base_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 sram_req_o,
  output logic                 sram_we_o,
  output logic [ADDR_W-1:0]    sram_addr_o,
  output logic [31:0]          sram_wdata_o,
  input  logic [31:0]          sram_rdata_i
);
  localparam int MAX_FW   = MAX_KEY_BITS / 32;
  localparam int MAX_HW   = MAX_KEY_BITS / 64;
  localparam int WORD_W   = $clog2(MAX_FW);
  localparam int MAX_CODE = $clog2(MAX_KEY_BITS / 512);

  state_e            state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        code_q;
  logic              err_q;

  logic              p_vld_q, p_out_q;
  logic [2:0]        p_comp_q;
  logic [WORD_W-1:0] p_word_q;
  logic [ADDR_W-1:0] p_offs_q;

  logic [2:0]        s_comp;
  logic [WORD_W-1:0] s_word;
  logic [ADDR_W-1:0] s_offs;
  logic              s_last;

  logic cmd_ok, active, accept;
  logic [31:0] bank_rdata [NUM_COMP];

  always_comb begin
    cmd_ok = (slot_i < SLOT_IN_W'(NUM_SLOTS)) && (cmd_i != CMD_RSVD) &&
             ((cmd_i == CMD_CLEAR) || (klen_i <= 2'(MAX_CODE)));
    active = (state_q == ST_COPY_IN) || (state_q == ST_COPY_OUT) ||
             (state_q == ST_CLEAR);
    accept = (state_q == ST_IDLE) && start_i && cmd_ok;
  end

  kstore_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (accept),
    .step_i     (active),
    .len_code_i (code_q),
    .comp_o     (s_comp),
    .word_o     (s_word),
    .offs_o     (s_offs),
    .last_o     (s_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      base_q  <= '0;
      code_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (cmd_ok) begin
            err_q  <= 1'b0;
            slot_q <= slot_i[SLOT_W-1:0];
            base_q <= base_i;
            code_q <= (cmd_i == CMD_CLEAR) ? 2'(MAX_CODE) : klen_i;
            unique case (cmd_i)
              CMD_LOAD: state_q <= ST_COPY_IN;
              CMD_READ: state_q <= ST_COPY_OUT;
              default:  state_q <= ST_CLEAR;
            endcase
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_COPY_IN, ST_COPY_OUT, ST_CLEAR: if (s_last) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // stage 2 of the copy: data arrives from SRAM or from a bank one cycle late
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_q  <= 1'b0;
      p_out_q  <= 1'b0;
      p_comp_q <= '0;
      p_word_q <= '0;
      p_offs_q <= '0;
    end else begin
      p_vld_q  <= (state_q == ST_COPY_IN) || (state_q == ST_COPY_OUT);
      p_out_q  <= (state_q == ST_COPY_OUT);
      p_comp_q <= s_comp;
      p_word_q <= s_word;
      p_offs_q <= s_offs;
    end
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
    localparam int DEPTH = ((c >= 2) && (c <= 4)) ? MAX_FW : MAX_HW;
    logic we;
    always_comb begin
      we = (p_vld_q && !p_out_q && (p_comp_q == 3'(c))) ||
           ((state_q == ST_CLEAR) && (s_comp == 3'(c)));
    end
    kstore_bank #(
      .NUM_SLOTS (NUM_SLOTS),
      .DEPTH     (DEPTH),
      .SLOT_W    (SLOT_W),
      .WORD_W    (WORD_W)
    ) u_bank (
      .clk_i   (clk_i),
      .we_i    (we),
      .slot_i  (slot_q),
      .wword_i ((state_q == ST_CLEAR) ? s_word : p_word_q),
      .wdata_i ((state_q == ST_CLEAR) ? 32'd0 : sram_rdata_i),
      .rword_i (s_word),
      .rdata_o (bank_rdata[c])
    );
  end

  always_comb begin
    sram_we_o    = p_vld_q && p_out_q;
    sram_req_o   = (state_q == ST_COPY_IN) || sram_we_o;
    sram_addr_o  = base_q + (sram_we_o ? p_offs_q : s_offs);
    sram_wdata_o = bank_rdata[p_comp_q];
    busy_o       = (state_q != ST_IDLE);
    done_o       = (state_q == ST_DONE);
    err_o        = done_o && err_q;
  end
endmodule

// File: rtl/kstore_ctrl_chk.sv
module kstore_ctrl_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_IN_W = 3,
  parameter int ADDR_W    = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [1:0]           cmd_i,
  input logic [SLOT_IN_W-1:0] slot_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o,
  input logic                 sram_req_o,
  input logic                 sram_we_o,
  input logic [ADDR_W-1:0]    sram_addr_o
);
  logic slot_bad;
  assign slot_bad = (slot_i >= SLOT_IN_W'(NUM_SLOTS));

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && !sram_req_o)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o && $past(sram_req_o)) |-> (sram_addr_o == $past(sram_addr_o) + ADDR_W'(1))); // R2

  AST_SLOT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && slot_bad) |=> (done_o && err_o && !sram_req_o)); // R5

  AST_CMD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cmd_i == 2'd3) |=> (done_o && err_o)); // R6

  AST_CLEAR_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !slot_bad && cmd_i == 2'd2) |=> (busy_o && !done_o)); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10

  AST_IDLE_NO_SRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sram_req_o); // R11

  AST_WE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> sram_req_o); // R11
endmodule

bind kstore_ctrl kstore_ctrl_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .SLOT_IN_W (SLOT_IN_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmd_i       (cmd_i),
  .slot_i      (slot_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .sram_req_o  (sram_req_o),
  .sram_we_o   (sram_we_o),
  .sram_addr_o (sram_addr_o)
);

// File: tb/kstore_ctrl_tb.sv
`timescale 1ns/1ps
module kstore_ctrl_tb;
  localparam int ADDR_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = '0;
  logic [2:0]  slot = '0;
  logic [1:0]  klen = '0;
  logic [ADDR_W-1:0] base = '0;
  logic        busy, done, err, req, we;
  logic [ADDR_W-1:0] addr;
  logic [31:0] wdata, rdata;

  logic [31:0] sram [1024];
  logic        host_we = 1'b0;
  int          host_addr = 0;
  logic [31:0] host_data = '0;

  int checks = 0, errors = 0, req_cnt = 0, we_cnt = 0, cyc_total = 0;

  always #2.5 clk = ~clk;

  kstore_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .slot_i(slot),
    .klen_i(klen), .base_i(base), .busy_o(busy), .done_o(done), .err_o(err),
    .sram_req_o(req), .sram_we_o(we), .sram_addr_o(addr),
    .sram_wdata_o(wdata), .sram_rdata_i(rdata)
  );

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (host_we) sram[host_addr[9:0]] <= host_data;
    if (req) begin
      req_cnt <= req_cnt + 1;
      if (we) begin
        we_cnt <= we_cnt + 1;
        sram[addr[9:0]] <= wdata;
      end else begin
        rdata <= sram[addr[9:0]];
      end
    end
  end

  function automatic logic [31:0] pat(input int seed, input int i);
    logic [31:0] s, w;
    s = seed; w = i;
    return {s[15:0], w[15:0]};
  endfunction
  function automatic int clen(input int code, input int c);
    return (c >= 2 && c <= 4) ? (16 << code) : (8 << code);
  endfunction
  function automatic int coff(input int code, input int c);
    int o = 0;
    for (int j = 0; j < c; j++) o += clen(code, j);
    return o;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(input int b, input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = b + i; host_data = pat(seed, i);
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run_cmd(input int c, input int s, input int k, input int b,
                         input bit exp_err, input int exp_cyc, input int exp_req,
                         input int intr_at, input string rq);
    int cyc, r0;
    cyc = 0;
    r0 = req_cnt;
    @(negedge clk);
    start = 1'b1; cmd = 2'(c); slot = 3'(s); klen = 2'(k); base = ADDR_W'(b);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 2000) begin
      if (cyc == intr_at) begin
        start = 1'b1; cmd = 2'd2; slot = 3'd3;
      end
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(err == exp_err, rq, "err_o with done_o", int'(err), int'(exp_err));
    chk(cyc == exp_cyc, rq, "busy cycles before done", cyc, exp_cyc);
    @(negedge clk);
    chk(!done && !busy, "R10", "done/busy after pulse", int'({done, busy}), 0);
    chk(req_cnt - r0 == exp_req, rq, "SRAM accesses", req_cnt - r0, exp_req);
  endtask

  task automatic check_copy(input int b, input int seed, input int n, input string rq);
    int bad = 0, first = -1;
    for (int i = 0; i < n; i++)
      if (sram[b + i] !== pat(seed, i)) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, rq, "copied region mismatches", bad, 0);
    if (first >= 0) chk(1'b0, rq, "first bad word", int'(sram[b + first]), int'(pat(seed, first)));
  endtask

  task automatic check_zero(input int b, input int n, input string rq);
    int bad = 0;
    for (int i = 0; i < n; i++) if (sram[b + i] !== 32'd0) bad++;
    chk(bad == 0, rq, "nonzero words in cleared slot", bad, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !req, "R1", "outputs after reset",
        int'({busy, done, err, req}), 0);
  endtask

  task automatic t_clear_all();
    fill(600, 16'hEEEE, 176);
    for (int s = 0; s < 4; s++) run_cmd(2, s, 0, 0, 1'b0, 176, 0, -1, "R7");
    run_cmd(1, 0, 1, 600, 1'b0, 176, 176, -1, "R3");
    check_zero(600, 176, "R7");
  endtask

  task automatic t_load_full();
    int w0;
    fill(0, 16'h0011, 176);
    w0 = we_cnt;
    run_cmd(0, 0, 1, 0, 1'b0, 176, 176, -1, "R2");
    chk(we_cnt == w0, "R11", "writes during load", we_cnt - w0, 0);
    fill(400, 16'hDEAD, 176);
    run_cmd(1, 0, 1, 400, 1'b0, 176, 176, -1, "R3");
    check_copy(400, 16'h0011, 176, "R3");
  endtask

  task automatic t_short_key();
    int bad = 0;
    fill(200, 16'h0022, 88);
    run_cmd(0, 2, 0, 200, 1'b0, 88, 88, -1, "R2");
    fill(600, 16'hBEEF, 176);
    run_cmd(1, 2, 1, 600, 1'b0, 176, 176, -1, "R4");
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < clen(1, c); w++) begin
        logic [31:0] e;
        e = (w < clen(0, c)) ? pat(16'h0022, coff(0, c) + w) : 32'd0;
        if (sram[600 + coff(1, c) + w] !== e) bad++;
      end
    chk(bad == 0, "R4", "component layout of 512-bit key in 1024 view", bad, 0);
    fill(800, 16'hBEEF, 88);
    run_cmd(1, 2, 0, 800, 1'b0, 88, 88, -1, "R4");
    check_copy(800, 16'h0022, 88, "R4");
  endtask

  task automatic t_independent();
    fill(400, 16'hDEAD, 176);
    run_cmd(1, 0, 1, 400, 1'b0, 176, 176, -1, "R8");
    check_copy(400, 16'h0011, 176, "R8");
  endtask

  task automatic t_rejects();
    fill(300, 16'h0055, 88);
    run_cmd(0, 5, 0, 300, 1'b1, 0, 0, -1, "R5");
    run_cmd(0, 1, 2, 300, 1'b1, 0, 0, -1, "R4");
    run_cmd(3, 1, 0, 300, 1'b1, 0, 0, -1, "R6");
    fill(600, 16'hBEEF, 176);
    run_cmd(1, 1, 1, 600, 1'b0, 176, 176, -1, "R5");
    check_zero(600, 176, "R5");
  endtask

  task automatic t_busy_ignore();
    run_cmd(0, 3, 0, 200, 1'b0, 88, 88, 10, "R9");
    fill(800, 16'hBEEF, 88);
    run_cmd(1, 3, 0, 800, 1'b0, 88, 88, -1, "R9");
    check_copy(800, 16'h0022, 88, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear_all();
    t_load_full();
    t_short_key();
    t_independent();
    t_rejects();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc_total >= 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule